// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs a single serial-flash command frame on an SPI bus that operates in clock mode 3. Software first loads an address register and a data register. It then writes a command word. That write starts the frame. An opcode byte goes out first. Address bytes follow, then dummy bytes, then a group of data bytes. The data bytes are either sent from the data register or received into it. A status register shows whether a command is still running and whether a rejected command has latched an error.

A flag in the command word can keep chip select asserted when a command ends. Several short commands can then form one longer flash transaction. A command that arrives while the frame is still open does not repeat the opcode; it simply adds its address, dummy and data bytes to the frame. The serial clock comes from a simple internal half-period counter.

Top module: `sfc_cmd_seq`

## Requirements
- R1: Register select 0 is the address register, which holds 24 bits and reads back with bits 31:24 zero. Select 1 is the data register, 2 is the command register and 3 is status. After reset every register reads 0, all chip selects are high and the serial clock is high.
- R2: Command word fields:
  - opcode in bits 7:0
  - write flag in bit 8
  - data byte count in bits 11:9
  - keep-selected flag in bit 15
  - dummy byte count in bits 19:16
  - address byte count in bits 22:20
  - chip select index in bits 26:24
- R3: An accepted command sends its bytes in this order: the opcode, then the address bytes, then the dummy bytes, then the data bytes. The opcode is sent only when no frame was being held open.
- R4: Address bytes are taken from the address register. The most significant byte in use goes first: bits 23:16 for a count of 3, bits 15:8 for a count of 2, bits 7:0 for a count of 1.
- R5: On a write, data byte i is taken from data register bits 8i+7:8i, with byte 0 sent first. On a read, the i-th received byte is stored in the same position. Data bytes beyond the count are left unchanged.
- R6: Status bit 22 (pending) reads 1 from the cycle after an accepted command write until the frame has finished.
- R7: A command write while pending is set makes status bit 29 (error) become 1, and that command sends nothing. Writing status with bit 29 set clears the error.
- R8: With keep-selected set, chip select stays low after the command ends. With it clear, chip select goes high at the end.
- R9: A command with address count 0, data count 0 and keep-selected clear sends no bytes at all, whatever its dummy count, and only releases chip select.
- R10: The serial clock idles high. MOSI changes only while the clock is low. MISO is sampled on the rising edge. Each byte is shifted most significant bit first.
- R11: Dummy bytes drive MOSI low. Bytes received during address, dummy and write phases are not stored.
- R12: Chip select index k drives cs_n[k] low, and at most one line is low at a time. An index of CS_COUNT or above sets the error bit, and that command sends nothing. A data count above 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_COUNT | Active-low chip selects |

## Verification
The bench builds the block with SCK_HALF = 2 and CS_COUNT = 4. The short clock period keeps each byte to 32 cycles, so frames that use the full three address bytes, several dummy bytes and four data bytes all fit in a short run. With four selects, the bench can reach both an in-range index on an upper line and an out-of-range index (5) that the 3-bit field can still encode.

A slave model in the bench returns a byte value that depends on the byte's position in the frame. Any misplaced dummy byte or wrongly ordered read byte therefore shows up in the data register.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam logic [1:0] REG_ADDR = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_CMD  = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int STAT_PEND_BIT = 22;
    localparam int STAT_ERR_BIT  = 29;
    localparam int MAX_DATA      = 4;

    typedef struct packed {
        logic [2:0] cs_idx;
        logic [2:0] alen;
        logic [3:0] dumlen;
        logic       keep;
        logic [2:0] dlen;
        logic       wr;
        logic [7:0] opcode;
    } sfc_cmd_t;

    typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DUM, PH_DATA} sfc_phase_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT, SQ_FINISH} sfc_state_e;

    function automatic sfc_cmd_t decode_cmd(input logic [31:0] w);
        sfc_cmd_t c;
        c.opcode = w[7:0];
        c.wr     = w[8];
        c.dlen   = (w[11:9] > 3'(MAX_DATA)) ? 3'(MAX_DATA) : w[11:9];
        c.keep   = w[15];
        c.dumlen = w[19:16];
        c.alen   = (w[22:20] > 3'd3) ? 3'd3 : w[22:20];
        c.cs_idx = w[26:24];
        return c;
    endfunction

    function automatic logic [3:0] phase_len(input sfc_phase_e p, input sfc_cmd_t c);
        case (p)
            PH_OPC:  return 4'd1;
            PH_ADDR: return {1'b0, c.alen};
            PH_DUM:  return c.dumlen;
            default: return {1'b0, c.dlen};
        endcase
    endfunction

    // returns {found, phase}
    function automatic logic [2:0] next_phase(input sfc_phase_e from, input sfc_cmd_t c);
        if (from == PH_OPC && c.alen != 3'd0)
            return {1'b1, PH_ADDR};
        if ((from == PH_OPC || from == PH_ADDR) && c.dumlen != 4'd0)
            return {1'b1, PH_DUM};
        if (from != PH_DATA && c.dlen != 3'd0)
            return {1'b1, PH_DATA};
        return 3'b000;
    endfunction

endpackage

// File: rtl/sfc_byte_shifter.sv
module sfc_byte_shifter #(
    parameter int SCK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);
    localparam int HCW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [HCW-1:0] HALF_LAST = HCW'(SCK_HALF - 1);

    typedef struct packed {
        logic           busy;
        logic           sck;
        logic           mosi;
        logic [HCW-1:0] half;
        logic [2:0]     bits;
        logic [7:0]     sh;
        logic [7:0]     rx;
        logic           done;
    } shift_st_t;

    shift_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.sh   = tx_byte;
                st_d.half = '0;
                st_d.bits = 3'd0;
            end
        end else if (st_q.half == HALF_LAST) begin
            st_d.half = '0;
            if (st_q.sck) begin
                // falling edge: launch next bit
                st_d.sck  = 1'b0;
                st_d.mosi = st_q.sh[7];
            end else begin
                // rising edge: sample
                st_d.sck  = 1'b1;
                st_d.rx   = {st_q.rx[6:0], miso};
                st_d.sh   = {st_q.sh[6:0], 1'b0};
                st_d.bits = st_q.bits + 3'd1;
                if (st_q.bits == 3'd7) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end else begin
            st_d.half = st_q.half + HCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sck <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign rx_byte = st_q.rx;
    assign sck     = st_q.sck;
    assign mosi    = st_q.mosi;

    // R10
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> st_q.sck);
    // R10
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sck && st_d.sck) |=> $stable(mosi));

endmodule

// File: rtl/sfc_sequencer.sv
module sfc_sequencer
    import sfc_pkg::*;
#(
    parameter int CS_COUNT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  sfc_cmd_t            cmd,
    input  logic [23:0]         addr,
    input  logic [31:0]         wdata,
    output logic                busy,
    output logic                rx_we,
    output logic [1:0]          rx_idx,
    output logic                sh_start,
    output logic [7:0]          sh_tx,
    input  logic                sh_done,
    output logic [CS_COUNT-1:0] cs_n
);
    localparam int CSW = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1;

    typedef struct packed {
        sfc_state_e     state;
        sfc_phase_e     phase;
        sfc_cmd_t       cmd;
        logic [3:0]     cnt;
        logic [3:0]     idx;
        logic           open;
        logic [CSW-1:0] sel;
        logic [23:0]    addr;
        logic [31:0]    wdata;
    } seq_st_t;

    seq_st_t sq_q, sq_d;
    logic [2:0] nx;
    logic [2:0] abyte;

    always_comb begin
        sq_d     = sq_q;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        rx_we    = 1'b0;
        rx_idx   = sq_q.idx[1:0];
        nx       = 3'b000;
        abyte    = sq_q.cmd.alen - 3'd1 - sq_q.idx[2:0];
        case (sq_q.state)
            SQ_IDLE: begin
                if (start) begin
                    sq_d.cmd   = cmd;
                    sq_d.addr  = addr;
                    sq_d.wdata = wdata;
                    sq_d.idx   = 4'd0;
                    if (cmd.alen == 3'd0 && cmd.dlen == 3'd0 && !cmd.keep) begin
                        sq_d.state = SQ_FINISH;
                    end else begin
                        sq_d.open = 1'b1;
                        if (!sq_q.open) begin
                            sq_d.sel   = CSW'(cmd.cs_idx);
                            sq_d.phase = PH_OPC;
                            sq_d.cnt   = 4'd1;
                            sq_d.state = SQ_LAUNCH;
                        end else begin
                            nx = next_phase(PH_OPC, cmd);
                            if (nx[2]) begin
                                sq_d.phase = sfc_phase_e'(nx[1:0]);
                                sq_d.cnt   = phase_len(sfc_phase_e'(nx[1:0]), cmd);
                                sq_d.state = SQ_LAUNCH;
                            end else begin
                                sq_d.state = SQ_FINISH;
                            end
                        end
                    end
                end
            end
            SQ_LAUNCH: begin
                sh_start = 1'b1;
                case (sq_q.phase)
                    PH_OPC:  sh_tx = sq_q.cmd.opcode;
                    PH_ADDR: begin
                        case (abyte)
                            3'd0:    sh_tx = sq_q.addr[7:0];
                            3'd1:    sh_tx = sq_q.addr[15:8];
                            default: sh_tx = sq_q.addr[23:16];
                        endcase
                    end
                    PH_DUM:  sh_tx = 8'h00;
                    default: sh_tx = sq_q.cmd.wr ? sq_q.wdata[8*sq_q.idx[1:0] +: 8] : 8'h00;
                endcase
                sq_d.state = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (sh_done) begin
                    rx_we = (sq_q.phase == PH_DATA) && !sq_q.cmd.wr;
                    if (sq_q.cnt > 4'd1) begin
                        sq_d.cnt   = sq_q.cnt - 4'd1;
                        sq_d.idx   = sq_q.idx + 4'd1;
                        sq_d.state = SQ_LAUNCH;
                    end else begin
                        nx = next_phase(sq_q.phase, sq_q.cmd);
                        if (nx[2]) begin
                            sq_d.phase = sfc_phase_e'(nx[1:0]);
                            sq_d.cnt   = phase_len(sfc_phase_e'(nx[1:0]), sq_q.cmd);
                            sq_d.idx   = 4'd0;
                            sq_d.state = SQ_LAUNCH;
                        end else begin
                            sq_d.state = SQ_FINISH;
                        end
                    end
                end
            end
            default: begin
                if (!sq_q.cmd.keep)
                    sq_d.open = 1'b0;
                sq_d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sq_q <= '0;
        else
            sq_q <= sq_d;
    end

    assign busy = (sq_q.state != SQ_IDLE);

    for (genvar g = 0; g < CS_COUNT; g++) begin : g_cs
        assign cs_n[g] = !(sq_q.open && sq_q.sel == CSW'(g));
    end

    // R12
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R8
    keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == SQ_FINISH && sq_q.cmd.keep) |=> !(&cs_n));
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == SQ_FINISH && !sq_q.cmd.keep) |=> (&cs_n));
    // R3
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !sh_start);

endmodule

// File: rtl/sfc_cmd_seq.sv
module sfc_cmd_seq
    import sfc_pkg::*;
#(
    parameter int SCK_HALF = 4,
    parameter int CS_COUNT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_COUNT-1:0] cs_n
);
    typedef struct packed {
        logic [23:0] addr;
        logic [31:0] data;
        logic [31:0] cmd;
        logic        err;
    } regs_t;

    regs_t rg_q, rg_d;

    logic       launch;
    logic       busy;
    logic       rx_we;
    logic [1:0] rx_idx;
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_done;
    logic [7:0] sh_rx;
    logic       bad_cs;
    logic       set_err;

    assign bad_cs = (32'(reg_wdata[26:24]) >= CS_COUNT);

    always_comb begin
        rg_d    = rg_q;
        launch  = 1'b0;
        set_err = 1'b0;
        if (reg_wr) begin
            case (reg_sel)
                REG_ADDR: rg_d.addr = reg_wdata[23:0];
                REG_DATA: rg_d.data = reg_wdata;
                REG_CMD: begin
                    if (busy || bad_cs) begin
                        set_err = 1'b1;
                    end else begin
                        rg_d.cmd = reg_wdata;
                        launch   = 1'b1;
                    end
                end
                default: begin
                    if (reg_wdata[STAT_ERR_BIT])
                        rg_d.err = 1'b0;
                end
            endcase
        end
        if (rx_we)
            rg_d.data[8*rx_idx +: 8] = sh_rx;
        if (set_err)
            rg_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rg_q <= '0;
        else
            rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = 32'h0;
        case (reg_sel)
            REG_ADDR: reg_rdata = {8'h00, rg_q.addr};
            REG_DATA: reg_rdata = rg_q.data;
            REG_CMD:  reg_rdata = rg_q.cmd;
            default: begin
                reg_rdata[STAT_PEND_BIT] = busy;
                reg_rdata[STAT_ERR_BIT]  = rg_q.err;
            end
        endcase
    end

    sfc_sequencer #(.CS_COUNT(CS_COUNT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .cmd      (decode_cmd(reg_wdata)),
        .addr     (rg_q.addr),
        .wdata    (rg_q.data),
        .busy     (busy),
        .rx_we    (rx_we),
        .rx_idx   (rx_idx),
        .sh_start (sh_start),
        .sh_tx    (sh_tx),
        .sh_done  (sh_done),
        .cs_n     (cs_n)
    );

    sfc_byte_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (miso),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sck     (sck),
        .mosi    (mosi)
    );

    // R7
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_CMD && busy) |=> rg_q.err);
    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_STAT && reg_wdata[STAT_ERR_BIT]) |=> !rg_q.err);
    // R6
    launch_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_CMD && !busy && !bad_cs) |=> busy);
    // R12
    bad_cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_CMD && !busy && bad_cs) |=> (!busy && rg_q.err));

endmodule

// File: tb/sfc_cmd_seq_tb.sv
module sfc_cmd_seq_tb;
    localparam int CSN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        sck, mosi;
    logic        miso = 1'b0;
    logic [CSN-1:0] cs_n;

    int total = 0;
    int fails = 0;
    int stab_err = 0;

    always #2.5 clk = ~clk;

    sfc_cmd_seq #(.SCK_HALF(2), .CS_COUNT(CSN)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    // scoreboard of expected MOSI bytes
    logic [7:0] exp_v[$];
    string      exp_r[$];

    task automatic expect_byte(input logic [7:0] v, input string r);
        exp_v.push_back(v);
        exp_r.push_back(r);
    endtask

    function automatic logic [7:0] resp(input int i);
        return 8'h5A + 8'(i * 37);
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] opc, input logic wr,
        input logic [2:0] dlen, input logic keep, input logic [3:0] dum,
        input logic [2:0] alen, input logic [2:0] cs);
        return {5'b0, cs, 1'b0, alen, dum, keep, 3'b0, dlen, wr, opc};
    endfunction

    // slave model and monitor
    logic cs_idle;
    assign cs_idle = &cs_n;
    int fidx = 0;
    int bitc = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] got = 8'h00;

    always @(posedge cs_idle) begin
        fidx = 0;
        bitc = 0;
    end

    always @(negedge sck) begin
        if (!cs_idle) begin
            if (bitc == 0) cur = resp(fidx);
            #1 miso = cur[7 - bitc];
        end
    end

    always @(posedge sck) begin
        if (!cs_idle) begin
            got = {got[6:0], mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                fidx++;
                if (exp_v.size() == 0) begin
                    total++;
                    fails++;
                    $display("FAIL R3: actual %h expected no byte", got);
                end else begin
                    chk(exp_r.pop_front(), {24'h0, got}, {24'h0, exp_v.pop_front()});
                end
            end
        end
    end

    // R10: MOSI must not move while SCK stays high
    logic prev_sck = 1'b1, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_sck && sck && mosi !== prev_mosi) stab_err++;
        prev_sck  = sck;
        prev_mosi = mosi;
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do begin
            @(negedge clk);
            rd(2'd3, v);
        end while (v[22]);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_drained(input string r);
        chk(r, 32'(exp_v.size()), 32'd0);
    endtask

    logic [31:0] v;

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 addr reset", v, 32'h0);
        rd(2'd1, v); chk("R1 data reset", v, 32'h0);
        rd(2'd2, v); chk("R1 cmd reset", v, 32'h0);
        rd(2'd3, v); chk("R1 stat reset", v, 32'h0);
        chk("R1 cs_n reset", 32'(cs_n), 32'hF);
        chk("R10 sck idle", 32'(sck), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 address register keeps 24 bits
        wr(2'd0, 32'hFF123456);
        rd(2'd0, v); chk("R1 addr wrap", v, 32'h00123456);

        // R3 R4 R11 R5: read with 3 address bytes, 2 dummy, 4 data
        expect_byte(8'h0B, "R3 opcode");
        expect_byte(8'h12, "R4 addr hi");
        expect_byte(8'h34, "R4 addr mid");
        expect_byte(8'h56, "R4 addr lo");
        expect_byte(8'h00, "R11 dummy");
        expect_byte(8'h00, "R11 dummy");
        for (int i = 0; i < 4; i++) expect_byte(8'h00, "R5 read mosi");
        wr(2'd2, mk(8'h0B, 1'b0, 3'd4, 1'b0, 4'd2, 3'd3, 3'd1));
        rd(2'd3, v); chk("R6 pending set", v, 32'h00400000);
        chk("R12 cs1 low", 32'(cs_n), 32'hD);
        wait_idle();
        rd(2'd1, v); chk("R5 R11 read data", v, {resp(9), resp(8), resp(7), resp(6)});
        chk("R8 release", 32'(cs_n), 32'hF);
        check_drained("R3 frame1");

        // R5 write, R8 keep
        wr(2'd0, 32'h00ABCDEF);
        wr(2'd1, 32'hDDCCBBAA);
        expect_byte(8'h02, "R3 opcode");
        expect_byte(8'hCD, "R4 addr2 hi");
        expect_byte(8'hEF, "R4 addr2 lo");
        expect_byte(8'hAA, "R5 wr b0");
        expect_byte(8'hBB, "R5 wr b1");
        expect_byte(8'hCC, "R5 wr b2");
        wr(2'd2, mk(8'h02, 1'b1, 3'd3, 1'b1, 4'd0, 3'd2, 3'd2));
        wait_idle();
        chk("R8 keep cs2", 32'(cs_n), 32'hB);
        rd(2'd3, v); chk("R6 pending clear", v, 32'h0);

        // R3 R8 continuation: no opcode repeated
        wr(2'd1, 32'h00000011);
        expect_byte(8'h11, "R3 continued data");
        wr(2'd2, mk(8'h77, 1'b1, 3'd1, 1'b0, 4'd0, 3'd0, 3'd0));
        wait_idle();
        chk("R8 end release", 32'(cs_n), 32'hF);
        check_drained("R3 frame2");

        // R7 command while pending
        expect_byte(8'h9F, "R3 opcode");
        expect_byte(8'h00, "R5 read mosi");
        expect_byte(8'h00, "R5 read mosi");
        wr(2'd2, mk(8'h9F, 1'b0, 3'd2, 1'b0, 4'd0, 3'd0, 3'd0));
        wr(2'd2, mk(8'h05, 1'b1, 3'd1, 1'b0, 4'd0, 3'd0, 3'd0));
        rd(2'd3, v); chk("R7 err while busy", v, 32'h20400000);
        wait_idle();
        rd(2'd1, v); chk("R5 partial read", v, {16'h0000, resp(2), resp(1)});
        rd(2'd3, v); chk("R7 err sticky", v, 32'h20000000);
        check_drained("R7 ignored cmd");
        wr(2'd3, 32'h20000000);
        rd(2'd3, v); chk("R7 err clear", v, 32'h0);

        // R9 opcode-only keep, then release-only
        expect_byte(8'h06, "R3 opcode only");
        wr(2'd2, mk(8'h06, 1'b1, 3'd0, 1'b1, 4'd0, 3'd0, 3'd3));
        wait_idle();
        chk("R8 keep cs3", 32'(cs_n), 32'h7);
        wr(2'd2, mk(8'hEE, 1'b0, 3'd0, 1'b0, 4'd5, 3'd0, 3'd0));
        wait_idle();
        chk("R9 release only", 32'(cs_n), 32'hF);
        check_drained("R9 no bytes");

        // R12 out-of-range select
        wr(2'd2, mk(8'h33, 1'b1, 3'd1, 1'b0, 4'd0, 3'd0, 3'd5));
        rd(2'd3, v); chk("R12 bad cs err", v, 32'h20000000);
        chk("R12 bad cs idle", 32'(cs_n), 32'hF);
        wait_idle();
        check_drained("R12 no bytes");
        wr(2'd3, 32'h20000000);

        // R12 data count clamp, R4 single address byte
        wr(2'd1, 32'h44332211);
        expect_byte(8'h12, "R3 opcode");
        expect_byte(8'hEF, "R4 addr1");
        expect_byte(8'h11, "R12 clamp b0");
        expect_byte(8'h22, "R12 clamp b1");
        expect_byte(8'h33, "R12 clamp b2");
        expect_byte(8'h44, "R12 clamp b3");
        wr(2'd2, mk(8'h12, 1'b1, 3'd7, 1'b0, 4'd0, 3'd1, 3'd0));
        wait_idle();
        check_drained("R12 clamp count");
        rd(2'd2, v); chk("R2 cmd readback", v, mk(8'h12, 1'b1, 3'd7, 1'b0, 4'd0, 3'd1, 3'd0));

        chk("R10 mosi stable while sck high", 32'(stab_err), 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule